// File: doc/BRIEF.md
# Parity-Check Early Stop Unit

This unit decides, after each full iteration of an iterative turbo decoder, whether the decoder can stop. The two soft-in soft-out constituent decoders each deliver soft values for their systematic and parity bits. This unit slices those soft values into hard bits and stores one block of them. It then runs two consistency checks against the stored block.

Check A interleaves the first decoder's systematic decisions and feeds them through the second constituent encoder. It compares the resulting parity stream with the second decoder's parity decisions. Check B de-interleaves the second decoder's systematic decisions and feeds them through the first constituent encoder. It compares that result with the first decoder's parity decisions. If either re-encoded stream agrees with its reference in every position of the block, the unit reports stop; otherwise it reports continue.

The permutation is held in a table that is written through a dedicated port before decoding. Check A reads the table to address the stored bits. Check B uses the same table as a write address while the block is captured. Soft values arrive on a valid/ready stream, one bit position per beat, with a marker on the first beat of a block.

Top module: `pcs_early_stop`

## Requirements
- R1: Each soft value (signed two's complement, W bits) is sliced to 1 when strictly greater than zero, and to 0 when zero or negative; this holds on all four lanes.
- R2: A beat with `in_sob`=1 begins a block at position 0. Beats accepted while idle with `in_sob`=0 are discarded. A beat with `in_sob`=1 during capture restarts the block at position 0.
- R3: Check A forms u[k] = sys1[perm[k]] for k = 0..N-1, encodes u in order of k, and compares the result with par2[k]. `chk_ok_a` reports 1 only if all N positions agree.
- R4: Check B forms v[perm[k]] = sys2[k], encodes v in order of position, and compares the result with par1 at the same position. `chk_ok_b` reports 1 only if all N positions agree.
- R5: The encoders use the recursive code with feedback 6 and feedforward 4 (octal): w[k] = u[k] XOR w[k-1] and parity[k] = w[k]. w[-1] is 0 at the start of every check of every block.
- R6: With `chk_done`=1, `chk_stop`=1 exactly when check A or check B agrees everywhere, and `chk_cont` is its complement. Both are 0 whenever `chk_done` is 0.
- R7: After the edge that accepts the N-th beat of a block, `in_ready` is 0 for exactly N cycles. `chk_done` is then 1 for exactly one cycle, and `in_ready` is 1 again in that cycle.
- R8: After reset, `in_ready`=1 and `chk_done`, `chk_stop`, `chk_cont`, `chk_ok_a`, `chk_ok_b` are all 0.
- R9: Table entries written through `perm_we`/`perm_waddr`/`perm_wdata` while no block is captured or checked define perm[] for all following blocks. The table must hold a permutation of 0..N-1.
- R10: The first beat of the next block is accepted in the same cycle that `chk_done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perm_we | input | 1 | Permutation table write enable |
| perm_waddr | input | AW | Table index k |
| perm_wdata | input | AW | Value perm[k] |
| in_valid | input | 1 | Beat valid |
| in_sob | input | 1 | Beat is position 0 of a block |
| llr_sys1 | input | W | First decoder systematic soft value |
| llr_par1 | input | W | First decoder parity soft value |
| llr_sys2 | input | W | Second decoder systematic soft value |
| llr_par2 | input | W | Second decoder parity soft value |
| in_ready | output | 1 | Unit accepts a beat |
| chk_done | output | 1 | One-cycle verdict strobe |
| chk_stop | output | 1 | Decoder may stop (with chk_done) |
| chk_cont | output | 1 | Decoder must iterate again (with chk_done) |
| chk_ok_a | output | 1 | Check A agreed everywhere, held until next verdict |
| chk_ok_b | output | 1 | Check B agreed everywhere, held until next verdict |

## Verification
The hardest outcome to reach is a block where one check agrees and the other does not. Consistent decoder outputs make both checks agree, and random outputs make both fail. The bench therefore builds each block from a random systematic sequence whose parities are derived through the current permutation, so both checks pass. It then corrupts a single parity decision: the last position on one lane, the first on the other. A zero soft value is also sent where a 1 was intended. This separates the two checks and shows that one agreeing check is enough to stop. Back-to-back blocks, resynchronising start markers and a table reload cover the sequencing corners.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int unsigned PCS_LANES = 4;

    typedef enum logic [1:0] {
        PCS_IDLE  = 2'd0,
        PCS_FILL  = 2'd1,
        PCS_CHECK = 2'd2
    } pcs_phase_e;

    // hard decisions of one beat
    typedef struct packed {
        logic sys1;
        logic par1;
        logic sys2;
        logic par2;
    } pcs_hard_t;

    // what is kept at natural position k
    typedef struct packed {
        logic sys1;
        logic par1;
        logic par2;
    } pcs_slot_t;

    typedef struct packed {
        logic stop;
        logic cont;
    } pcs_verdict_t;

    function automatic pcs_verdict_t pcs_decide(input logic ok_a, input logic ok_b);
        pcs_verdict_t v;
        v.stop = ok_a | ok_b;
        v.cont = ~(ok_a | ok_b);
        return v;
    endfunction

endpackage

// File: rtl/pcs_hard_slicer.sv
module pcs_hard_slicer #(
    parameter int W = 8
) (
    input  logic signed [W-1:0] llr,
    output logic                hard
);
    assign hard = ~llr[W-1] & (|llr);

    always_comb begin
        if (!$isunknown(llr)) begin
            assert_slice_sign_R1: assert ((llr > 0) == hard)
                else $error("slicer decision disagrees with sign");
        end
    end
endmodule

// File: rtl/pcs_rsc_encoder.sv
module pcs_rsc_encoder #(
    parameter int         K  = 3,
    parameter logic [K-1:0] FB = 3'o6,
    parameter logic [K-1:0] FF = 3'o4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic u,
    output logic par
);
    logic [K-1:1] sr;
    logic         w;

    always_comb begin
        w = u;
        for (int i = 1; i < K; i++) begin
            if (FB[K-1-i]) w = w ^ sr[i];
        end
        par = FF[K-1] & w;
        for (int i = 1; i < K; i++) begin
            if (FF[K-1-i]) par = par ^ sr[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr <= '0;
        end else if (en) begin
            sr[1] <= w;
            for (int i = 2; i < K; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    // R5: every check starts from the all-zero state
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sr == '0))
        else $error("encoder state not cleared");
endmodule

// File: rtl/pcs_perm_table.sv
module pcs_perm_table #(
    parameter int N  = 1600,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [AW-1:0] rdata
);
    logic [AW-1:0] tbl [N];

    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wdata;
    end

    assign rdata = tbl[raddr];

    assert_perm_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < N && int'(wdata) < N))
        else $error("permutation write out of range");
endmodule

// File: rtl/pcs_early_stop.sv
module pcs_early_stop
    import pcs_pkg::*;
#(
    parameter int           N  = 1600,
    parameter int           W  = 8,
    parameter int           K  = 3,
    parameter logic [K-1:0] FB = 3'o6,
    parameter logic [K-1:0] FF = 3'o4,
    localparam int          AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                perm_we,
    input  logic [AW-1:0]       perm_waddr,
    input  logic [AW-1:0]       perm_wdata,
    input  logic                in_valid,
    input  logic                in_sob,
    input  logic signed [W-1:0] llr_sys1,
    input  logic signed [W-1:0] llr_par1,
    input  logic signed [W-1:0] llr_sys2,
    input  logic signed [W-1:0] llr_par2,
    output logic                in_ready,
    output logic                chk_done,
    output logic                chk_stop,
    output logic                chk_cont,
    output logic                chk_ok_a,
    output logic                chk_ok_b
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);
    localparam logic [AW-1:0] ONE  = AW'(1);

    pcs_phase_e phase;
    logic [AW-1:0] idx;
    logic run_a, run_b;

    // ---------------- slicers ----------------
    logic signed [W-1:0] lane_llr [PCS_LANES];
    logic [PCS_LANES-1:0] lane_bit;
    pcs_hard_t hard;

    assign lane_llr[0] = llr_sys1;
    assign lane_llr[1] = llr_par1;
    assign lane_llr[2] = llr_sys2;
    assign lane_llr[3] = llr_par2;

    for (genvar g = 0; g < PCS_LANES; g++) begin : g_slice
        pcs_hard_slicer #(.W(W)) slicer_i (
            .llr  (lane_llr[g]),
            .hard (lane_bit[g])
        );
    end

    assign hard.sys1 = lane_bit[0];
    assign hard.par1 = lane_bit[1];
    assign hard.sys2 = lane_bit[2];
    assign hard.par2 = lane_bit[3];

    // ---------------- capture ----------------
    logic          beat, cap_we;
    logic [AW-1:0] wr_pos, perm_raddr, perm_rd;

    assign in_ready   = (phase != PCS_CHECK);
    assign beat       = in_valid & in_ready;
    assign cap_we     = beat & (in_sob | (phase == PCS_FILL));
    assign wr_pos     = in_sob ? '0 : idx;
    assign perm_raddr = (phase == PCS_CHECK) ? idx : wr_pos;

    pcs_perm_table #(.N(N), .AW(AW)) perm_i (
        .clk   (clk),
        .rst   (rst),
        .we    (perm_we),
        .waddr (perm_waddr),
        .wdata (perm_wdata),
        .raddr (perm_raddr),
        .rdata (perm_rd)
    );

    pcs_slot_t slot_mem  [N];
    logic      deint_mem [N];

    always_ff @(posedge clk) begin
        if (cap_we) begin
            slot_mem[wr_pos]   <= '{sys1: hard.sys1, par1: hard.par1, par2: hard.par2};
            deint_mem[perm_rd] <= hard.sys2;   // de-interleave on write
        end
    end

    // ---------------- check ----------------
    logic chk_act, bit_a, bit_b, par_a, par_b, hit_a, hit_b, fin_a, fin_b;
    pcs_slot_t here;

    assign chk_act = (phase == PCS_CHECK);
    assign bit_a   = slot_mem[perm_rd].sys1;  // interleave on read
    assign bit_b   = deint_mem[idx];
    assign here    = slot_mem[idx];

    pcs_rsc_encoder #(.K(K), .FB(FB), .FF(FF)) enc_a_i (
        .clk (clk), .rst (rst), .clr (~chk_act), .en (chk_act), .u (bit_a), .par (par_a)
    );
    pcs_rsc_encoder #(.K(K), .FB(FB), .FF(FF)) enc_b_i (
        .clk (clk), .rst (rst), .clr (~chk_act), .en (chk_act), .u (bit_b), .par (par_b)
    );

    assign hit_a = (par_a == here.par2);
    assign hit_b = (par_b == here.par1);
    assign fin_a = run_a & hit_a;
    assign fin_b = run_b & hit_b;

    // ---------------- sequencing ----------------
    pcs_verdict_t verdict;
    assign verdict = pcs_decide(fin_a, fin_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PCS_IDLE;
            idx      <= '0;
            run_a    <= 1'b1;
            run_b    <= 1'b1;
            chk_done <= 1'b0;
            chk_stop <= 1'b0;
            chk_cont <= 1'b0;
            chk_ok_a <= 1'b0;
            chk_ok_b <= 1'b0;
        end else begin
            chk_done <= 1'b0;
            chk_stop <= 1'b0;
            chk_cont <= 1'b0;
            unique case (phase)
                PCS_IDLE: begin
                    run_a <= 1'b1;
                    run_b <= 1'b1;
                    if (beat && in_sob) begin
                        idx   <= ONE;
                        phase <= PCS_FILL;
                    end
                end
                PCS_FILL: begin
                    run_a <= 1'b1;
                    run_b <= 1'b1;
                    if (beat) begin
                        if (in_sob) begin
                            idx <= ONE;
                        end else if (idx == LAST) begin
                            idx   <= '0;
                            phase <= PCS_CHECK;
                        end else begin
                            idx <= idx + ONE;
                        end
                    end
                end
                PCS_CHECK: begin
                    run_a <= fin_a;
                    run_b <= fin_b;
                    if (idx == LAST) begin
                        idx      <= '0;
                        phase    <= PCS_IDLE;
                        chk_done <= 1'b1;
                        chk_stop <= verdict.stop;
                        chk_cont <= verdict.cont;
                        chk_ok_a <= fin_a;
                        chk_ok_b <= fin_b;
                    end else begin
                        idx <= idx + ONE;
                    end
                end
                default: phase <= PCS_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        chk_done |=> !chk_done)
        else $error("verdict strobe longer than one cycle");

    assert_verdict_qualified_R6: assert property (@(posedge clk) disable iff (rst)
        (chk_stop || chk_cont) |-> (chk_done && (chk_stop != chk_cont)))
        else $error("stop/continue outside strobe or both set");

    assert_stop_needs_match_R6: assert property (@(posedge clk) disable iff (rst)
        chk_stop |-> (chk_ok_a || chk_ok_b))
        else $error("stop without an agreeing check");

    assert_sticky_a_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PCS_CHECK && !run_a) |=> !run_a)
        else $error("check A recovered after a mismatch");

    assert_sticky_b_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PCS_CHECK && !run_b) |=> !run_b)
        else $error("check B recovered after a mismatch");

    assert_ready_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> in_ready)
        else $error("not ready in the verdict cycle");
endmodule

// File: tb/pcs_early_stop_tb_top.sv
`timescale 1ns/1ps
module pcs_early_stop_tb_top;
    localparam int BLK = 40;
    localparam int W   = 8;
    localparam int AW  = $clog2(BLK);

    typedef struct {
        bit s1 [BLK];
        bit p1 [BLK];
        bit s2 [BLK];
        bit p2 [BLK];
    } blk_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic perm_we = 1'b0;
    logic [AW-1:0] perm_waddr = '0, perm_wdata = '0;
    logic in_valid = 1'b0, in_sob = 1'b0;
    logic signed [W-1:0] llr_sys1 = '0, llr_par1 = '0, llr_sys2 = '0, llr_par2 = '0;
    logic in_ready, chk_done, chk_stop, chk_cont, chk_ok_a, chk_ok_b;

    always #4 clk = ~clk;   // 125 MHz

    pcs_early_stop #(.N(BLK), .W(W)) dut_i (
        .clk(clk), .rst(rst),
        .perm_we(perm_we), .perm_waddr(perm_waddr), .perm_wdata(perm_wdata),
        .in_valid(in_valid), .in_sob(in_sob),
        .llr_sys1(llr_sys1), .llr_par1(llr_par1), .llr_sys2(llr_sys2), .llr_par2(llr_par2),
        .in_ready(in_ready), .chk_done(chk_done), .chk_stop(chk_stop), .chk_cont(chk_cont),
        .chk_ok_a(chk_ok_a), .chk_ok_b(chk_ok_b)
    );

    int n_checks = 0;
    int n_err    = 0;
    int perm_tb [BLK];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase = 0;
    int m_k = 0;
    int ncyc = 0;
    bit m_s1 [BLK], m_p1 [BLK], m_s2 [BLK], m_p2 [BLK];
    int m_perm [BLK];
    bit e_ready = 1, e_done = 0, e_stop = 0, e_cont = 0, e_oka = 0, e_okb = 0;

    function automatic bit sl(input logic signed [W-1:0] v);
        return (v > 0);   // R1
    endfunction

    function automatic bit model_a();   // R3, R5
        bit w = 0;
        bit ok = 1;
        for (int k = 0; k < BLK; k++) begin
            w = m_s1[m_perm[k]] ^ w;
            if (w != m_p2[k]) ok = 0;
        end
        return ok;
    endfunction

    function automatic bit model_b();   // R4, R5
        bit v [BLK];
        bit w = 0;
        bit ok = 1;
        for (int k = 0; k < BLK; k++) v[m_perm[k]] = m_s2[k];
        for (int j = 0; j < BLK; j++) begin
            w = v[j] ^ w;
            if (w != m_p1[j]) ok = 0;
        end
        return ok;
    endfunction

    task automatic m_store(input int pos);
        m_s1[pos] = sl(llr_sys1);
        m_p1[pos] = sl(llr_par1);
        m_s2[pos] = sl(llr_sys2);
        m_p2[pos] = sl(llr_par2);
    endtask

    always @(negedge clk) begin
        ncyc++;
        if (ncyc > 1) begin
            chk("R7", "done", int'(chk_done), int'(e_done));
            chk("R7", "ready", int'(in_ready), int'(e_ready));
            chk("R6", "stop", int'(chk_stop), int'(e_stop));
            chk("R6", "cont", int'(chk_cont), int'(e_cont));
            if (e_done) begin
                chk("R3", "ok_a", int'(chk_ok_a), int'(e_oka));
                chk("R4", "ok_b", int'(chk_ok_b), int'(e_okb));
            end
        end
        e_done = 0; e_stop = 0; e_cont = 0;
        if (perm_we) m_perm[perm_waddr] = int'(perm_wdata);
        if (rst) begin
            m_phase = 0; m_k = 0; e_oka = 0; e_okb = 0;
        end else begin
            case (m_phase)
                0: if (in_valid && in_sob) begin
                       m_store(0); m_k = 1; m_phase = 1;
                   end
                1: if (in_valid) begin
                       if (in_sob) m_k = 0;   // R2 resync
                       m_store(m_k);
                       m_k++;
                       if (m_k == BLK) begin m_k = 0; m_phase = 2; end
                   end
                default: begin
                       m_k++;
                       if (m_k == BLK) begin
                           e_oka = model_a(); e_okb = model_b();
                           e_done = 1; e_stop = e_oka | e_okb; e_cont = !e_stop;
                           m_phase = 0; m_k = 0;
                       end
                   end
            endcase
        end
        e_ready = (m_phase != 2);
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic signed [W-1:0] mk(input bit b, input int sel);
        logic signed [W-1:0] r;
        if (b) begin
            case (sel % 3)
                0: r = 8'sd1;
                1: r = 8'sd127;
                default: r = W'(1 + $urandom % 126);
            endcase
        end else begin
            case (sel % 3)
                0: r = 8'sd0;
                1: r = -8'sd128;
                default: r = -W'($urandom % 128);
            endcase
        end
        return r;
    endfunction

    function automatic blk_t make_good();
        blk_t b;
        bit w;
        for (int k = 0; k < BLK; k++) b.s1[k] = bit'($urandom % 2);
        for (int k = 0; k < BLK; k++) b.s2[k] = b.s1[perm_tb[k]];
        w = 0;
        for (int k = 0; k < BLK; k++) begin w = b.s1[perm_tb[k]] ^ w; b.p2[k] = w; end
        w = 0;
        for (int j = 0; j < BLK; j++) begin w = b.s1[j] ^ w; b.p1[j] = w; end
        return b;
    endfunction

    task automatic load_perm(input int mul, input int add);
        for (int k = 0; k < BLK; k++) begin
            perm_tb[k] = (mul * k + add) % BLK;
            perm_we = 1; perm_waddr = AW'(k); perm_wdata = AW'(perm_tb[k]);
            @(posedge clk); #1;
        end
        perm_we = 0;
    endtask

    task automatic put_beat(input bit sob, input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                            input logic signed [W-1:0] c, input logic signed [W-1:0] d);
        in_valid = 1; in_sob = sob;
        llr_sys1 = a; llr_par1 = b; llr_sys2 = c; llr_par2 = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 0; in_sob = 0;
    endtask

    task automatic send_block(input blk_t b, input int gap, input int zero_at);
        for (int k = 0; k < BLK; k++) begin
            put_beat(k == 0, mk(b.s1[k], k), mk(b.p1[k], k + 1), mk(b.s2[k], k + 2),
                     (k == zero_at) ? 8'sd0 : mk(b.p2[k], k + 3));
            repeat (gap) begin @(posedge clk); #1; end
        end
    endtask

    bit r_stop, r_cont, r_a, r_b;
    task automatic wait_done();
        int n = 0;
        do begin @(negedge clk); n++; end while (!chk_done && n < 5000);
        r_stop = chk_stop; r_cont = chk_cont; r_a = chk_ok_a; r_b = chk_ok_b;
    endtask

    task automatic expect_verdict(input string tag, input bit st, input bit a, input bit b);
        chk({"R6 ", tag}, "stop", int'(r_stop), int'(st));
        chk({"R6 ", tag}, "cont", int'(r_cont), int'(!st));
        chk({"R3 ", tag}, "ok_a", int'(r_a), int'(a));
        chk({"R4 ", tag}, "ok_b", int'(r_b), int'(b));
    endtask

    // ---------------- test sequence ----------------
    initial begin
        blk_t blk, blk2;
        int zpos;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R8 reset state
        chk("R8", "ready", int'(in_ready), 1);
        chk("R8", "done", int'(chk_done), 0);
        chk("R8", "stop", int'(chk_stop), 0);
        chk("R8", "cont", int'(chk_cont), 0);
        chk("R8", "ok_a", int'(chk_ok_a), 0);
        chk("R8", "ok_b", int'(chk_ok_b), 0);
        @(posedge clk); #1;
        load_perm(7, 3);

        // consistent block: both checks agree (R3 R4 R5)
        blk = make_good();
        send_block(blk, 0, -1);
        wait_done(); expect_verdict("R5 clean", 1, 1, 1);
        @(posedge clk); #1;

        // last position of par2 wrong: only check A fails
        blk = make_good(); blk.p2[BLK-1] = !blk.p2[BLK-1];
        send_block(blk, 0, -1);
        wait_done(); expect_verdict("R3 last", 1, 0, 1);
        @(posedge clk); #1;

        // first position of par1 wrong: only check B fails
        blk = make_good(); blk.p1[0] = !blk.p1[0];
        send_block(blk, 1, -1);
        wait_done(); expect_verdict("R4 first", 1, 1, 0);
        @(posedge clk); #1;

        // both wrong: continue
        blk = make_good(); blk.p2[5] = !blk.p2[5]; blk.p1[20] = !blk.p1[20];
        send_block(blk, 0, -1);
        wait_done(); expect_verdict("both bad", 0, 0, 0);
        @(posedge clk); #1;

        // R1: a zero soft value where a 1 was meant slices to 0
        blk = make_good(); zpos = -1;
        for (int k = 0; k < BLK; k++) if (zpos < 0 && blk.p2[k]) zpos = k;
        if (zpos < 0) begin blk.s1 = '{default: 1}; blk = make_good(); zpos = 0; end
        send_block(blk, 0, zpos);
        wait_done(); expect_verdict("R1 zero", blk.p2[zpos] ? 1 : 1, blk.p2[zpos] ? 0 : 1, 1);
        @(posedge clk); #1;

        // R2: junk while idle, aborted partial block, then a full one
        for (int j = 0; j < 3; j++) put_beat(0, 8'sd50, -8'sd3, 8'sd9, 8'sd1);
        for (int j = 0; j < 10; j++) put_beat(j == 0, 8'sd5, 8'sd5, -8'sd5, 8'sd5);
        blk = make_good();
        send_block(blk, 0, -1);
        wait_done(); expect_verdict("R2 resync", 1, 1, 1);
        @(posedge clk); #1;

        // R10: back-to-back blocks, second has both checks broken
        blk = make_good();
        blk2 = make_good(); blk2.p2[3] = !blk2.p2[3]; blk2.p1[3] = !blk2.p1[3];
        fork
            begin send_block(blk, 0, -1); send_block(blk2, 0, -1); end
            begin
                wait_done(); expect_verdict("R10 first", 1, 1, 1);
                chk("R10", "ready at done", int'(in_ready), 1);
                wait_done(); expect_verdict("R10 second", 0, 0, 0);
            end
        join
        @(posedge clk); #1;

        // R9: new permutation, gapped stream
        load_perm(13, 5);
        blk = make_good();
        send_block(blk, 2, -1);
        wait_done(); expect_verdict("R9 reload", 1, 1, 1);
        @(posedge clk); #1;

        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule